// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors notify each other over a small set of independent channels (six by default). Every channel carries one flag per direction. A processor raises its own flag for a channel to say "message posted". The other processor sees that flag as an occupied receive channel. When the receiver has taken the message, it writes a clear command. That clear drops the sender's flag, so the sender sees the channel as free again.

Each processor has its own register port, made of valid, write, word address and write data, with registered read data. Through it each processor reaches four words:

| Word | Name | Access | Contents |
|------|------|--------|----------|
| 0 | control | read/write | interrupt enables |
| 1 | mask | read/write | per-channel interrupt masks |
| 2 | command | write-only | set and clear bits |
| 3 | status | read-only | the processor's own flags |

Two interrupt lines go to each processor. The receive-occupied line combines the peer's flags with the receiver's occupied mask. The transmit-free line combines the processor's own cleared flags with its free mask. Each line is then gated by its enable bit in the control word.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After reset, all flags are 0, every mask bit is 1 (mask word reads 0x003F_003F) and the control word reads 0. Both interrupt lines of both processors are 0.
- R2: Writing word 2 with bit 16+k set raises the writing processor's own flag k. Bits written as 0 change nothing. Reading word 3 returns the processor's own flags in bits [5:0].
- R3: Writing word 2 with bit k (k in 0..5) set clears the peer processor's flag k.
- R4: A clear always wins over a set of the same flag. This holds when one write carries set bit 16+k and clear bit k: neither flag k is raised and the peer flag k is cleared. It also holds when one processor sets flag k in the same cycle that the other clears it: the flag stays 0.
- R5: The transmit-free line of processor p is 1 when its control bit 1 is 1 and some channel k has its own flag k at 0 and mask bit 16+k at 0.
- R6: The receive-occupied line of processor p is 1 when its control bit 0 is 1 and some channel k has the peer's flag k at 1 and mask bit k at 0.
- R7: With an enable bit at 0, the matching interrupt line stays 0 whatever the flags and masks.
- R8: Read data appears on the cycle after the read request. Words 0 and 1 read back the written fields. Word 2 and any address above 3 read 0. Writes to word 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 2 | Per-processor access request |
| bus_write | input | 2 | Per-processor 1 = write, 0 = read |
| bus_addr | input | 2 x ADDR_W | Per-processor word address |
| bus_wdata | input | 2 x DATA_W | Per-processor write data |
| bus_rdata | output | 2 x DATA_W | Per-processor read data, registered |
| irq_rx_occ | output | 2 | Receive-occupied interrupt per processor |
| irq_tx_free | output | 2 | Transmit-free interrupt per processor |

## Verification
The two functions that can land in the same cycle are a sender raising its flag and the receiver clearing that same flag through its own command word. The bench provokes this by driving both processor ports in one cycle. In the first case both target channel 3, and the flag must end at 0. In the second case the two ports touch unrelated channels, and both effects must survive. The single-write form of the same conflict, with set and clear bits for one channel in one word, is also checked: the status words of both sides must show the clear winning.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned NPROC   = 2;
    localparam int unsigned HI_LSB  = 16;
    localparam int unsigned RX_IE_B = 0;
    localparam int unsigned TX_IE_B = 1;

    typedef enum logic [1:0] {
        W_CTRL   = 2'd0,
        W_MASK   = 2'd1,
        W_CMD    = 2'd2,
        W_STATUS = 2'd3
    } mbox_word_e;
endpackage

// File: rtl/mbox_cfg_regs.sv
module mbox_cfg_regs #(
    parameter int unsigned NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_ctrl,
    input  logic           wr_mask,
    input  logic           wr_rx_ie,
    input  logic           wr_tx_ie,
    input  logic [NCH-1:0] wr_occ_m,
    input  logic [NCH-1:0] wr_free_m,
    output logic           rx_ie,
    output logic           tx_ie,
    output logic [NCH-1:0] occ_m,
    output logic [NCH-1:0] free_m
);
    typedef struct packed {
        logic           rx_ie;
        logic           tx_ie;
        logic [NCH-1:0] occ_m;
        logic [NCH-1:0] free_m;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.rx_ie = wr_rx_ie;
            cfg_d.tx_ie = wr_tx_ie;
        end
        if (wr_mask) begin
            cfg_d.occ_m  = wr_occ_m;
            cfg_d.free_m = wr_free_m;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.rx_ie  <= 1'b0;
            cfg_q.tx_ie  <= 1'b0;
            cfg_q.occ_m  <= '1;
            cfg_q.free_m <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rx_ie  = cfg_q.rx_ie;
    assign tx_ie  = cfg_q.tx_ie;
    assign occ_m  = cfg_q.occ_m;
    assign free_m = cfg_q.free_m;
endmodule

// File: rtl/mbox_flag_bank.sv
module mbox_flag_bank #(
    parameter int unsigned NCH = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [mbox_pkg::NPROC-1:0][NCH-1:0] set_req,
    input  logic [mbox_pkg::NPROC-1:0][NCH-1:0] clr_req,
    output logic [mbox_pkg::NPROC-1:0][NCH-1:0] flags
);
    typedef struct packed {
        logic [mbox_pkg::NPROC-1:0][NCH-1:0] flag;
    } bank_t;

    bank_t bank_d, bank_q;

    // A processor's clear bits act on the peer's flags; clear beats set.
    always_comb begin
        bank_d = bank_q;
        for (int p = 0; p < int'(mbox_pkg::NPROC); p++) begin
            bank_d.flag[p] = (bank_q.flag[p] | set_req[p])
                           & ~clr_req[mbox_pkg::NPROC-1-p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign flags = bank_q.flag;
endmodule

// File: rtl/mbox_port.sv
module mbox_port #(
    parameter int unsigned NCH    = 6,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_ie,
    input  logic              tx_ie,
    input  logic [NCH-1:0]    occ_m,
    input  logic [NCH-1:0]    free_m,
    input  logic [NCH-1:0]    own_flags,
    output logic              wr_ctrl,
    output logic              wr_mask,
    output logic [NCH-1:0]    set_req,
    output logic [NCH-1:0]    clr_req,
    output logic [DATA_W-1:0] rdata
);
    import mbox_pkg::*;

    localparam int unsigned HI = HI_LSB;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t port_d, port_q;

    logic        in_range;
    mbox_word_e  word;
    logic [DATA_W-1:0] rd_word;

    assign in_range = (addr < ADDR_W'(4));
    assign word     = mbox_word_e'(addr[1:0]);

    always_comb begin
        wr_ctrl = 1'b0;
        wr_mask = 1'b0;
        set_req = '0;
        clr_req = '0;
        if (valid && write && in_range) begin
            unique case (word)
                W_CTRL: wr_ctrl = 1'b1;
                W_MASK: wr_mask = 1'b1;
                W_CMD: begin
                    clr_req = wdata[NCH-1:0];
                    set_req = wdata[HI +: NCH] & ~wdata[NCH-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        if (in_range) begin
            unique case (word)
                W_CTRL: begin
                    rd_word[RX_IE_B] = rx_ie;
                    rd_word[TX_IE_B] = tx_ie;
                end
                W_MASK: begin
                    rd_word[NCH-1:0]   = occ_m;
                    rd_word[HI +: NCH] = free_m;
                end
                W_STATUS: rd_word[NCH-1:0] = own_flags;
                default: ;
            endcase
        end
    end

    always_comb begin
        port_d = port_q;
        if (valid && !write) begin
            port_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign rdata = port_q.rdata;
endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen #(
    parameter int unsigned NCH = 6
) (
    input  logic           rx_ie,
    input  logic           tx_ie,
    input  logic [NCH-1:0] occ_m,
    input  logic [NCH-1:0] free_m,
    input  logic [NCH-1:0] own_flags,
    input  logic [NCH-1:0] peer_flags,
    output logic           irq_rx,
    output logic           irq_tx
);
    logic [NCH-1:0] rx_pend;
    logic [NCH-1:0] tx_pend;

    always_comb begin
        rx_pend = peer_flags & ~occ_m;
        tx_pend = ~own_flags & ~free_m;
        irq_rx  = rx_ie & (|rx_pend);
        irq_tx  = tx_ie & (|tx_pend);
    end
endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl #(
    parameter int unsigned NCH    = 6,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [mbox_pkg::NPROC-1:0]              bus_valid,
    input  logic [mbox_pkg::NPROC-1:0]              bus_write,
    input  logic [mbox_pkg::NPROC-1:0][ADDR_W-1:0]  bus_addr,
    input  logic [mbox_pkg::NPROC-1:0][DATA_W-1:0]  bus_wdata,
    output logic [mbox_pkg::NPROC-1:0][DATA_W-1:0]  bus_rdata,
    output logic [mbox_pkg::NPROC-1:0]              irq_rx_occ,
    output logic [mbox_pkg::NPROC-1:0]              irq_tx_free
);
    import mbox_pkg::*;

    logic [NPROC-1:0][NCH-1:0] flag_q;
    logic [NPROC-1:0][NCH-1:0] set_req;
    logic [NPROC-1:0][NCH-1:0] clr_req;
    logic [NPROC-1:0]          wr_ctrl;
    logic [NPROC-1:0]          wr_mask;
    logic [NPROC-1:0]          rx_ie;
    logic [NPROC-1:0]          tx_ie;
    logic [NPROC-1:0][NCH-1:0] occ_m;
    logic [NPROC-1:0][NCH-1:0] free_m;

    for (genvar p = 0; p < int'(NPROC); p++) begin : g_proc
        mbox_port #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid    (bus_valid[p]),
            .write    (bus_write[p]),
            .addr     (bus_addr[p]),
            .wdata    (bus_wdata[p]),
            .rx_ie    (rx_ie[p]),
            .tx_ie    (tx_ie[p]),
            .occ_m    (occ_m[p]),
            .free_m   (free_m[p]),
            .own_flags(flag_q[p]),
            .wr_ctrl  (wr_ctrl[p]),
            .wr_mask  (wr_mask[p]),
            .set_req  (set_req[p]),
            .clr_req  (clr_req[p]),
            .rdata    (bus_rdata[p])
        );

        mbox_cfg_regs #(.NCH(NCH)) u_cfg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (wr_ctrl[p]),
            .wr_mask  (wr_mask[p]),
            .wr_rx_ie (bus_wdata[p][RX_IE_B]),
            .wr_tx_ie (bus_wdata[p][TX_IE_B]),
            .wr_occ_m (bus_wdata[p][NCH-1:0]),
            .wr_free_m(bus_wdata[p][HI_LSB +: NCH]),
            .rx_ie    (rx_ie[p]),
            .tx_ie    (tx_ie[p]),
            .occ_m    (occ_m[p]),
            .free_m   (free_m[p])
        );

        mbox_irq_gen #(.NCH(NCH)) u_irq (
            .rx_ie     (rx_ie[p]),
            .tx_ie     (tx_ie[p]),
            .occ_m     (occ_m[p]),
            .free_m    (free_m[p]),
            .own_flags (flag_q[p]),
            .peer_flags(flag_q[NPROC-1-p]),
            .irq_rx    (irq_rx_occ[p]),
            .irq_tx    (irq_tx_free[p])
        );
    end

    mbox_flag_bank #(.NCH(NCH)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(set_req),
        .clr_req(clr_req),
        .flags  (flag_q)
    );
endmodule

// File: rtl/mbox_flag_ctrl_chk.sv
module mbox_flag_ctrl_chk #(
    parameter int unsigned NCH    = 6,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic [mbox_pkg::NPROC-1:0]              bus_valid,
    input logic [mbox_pkg::NPROC-1:0]              bus_write,
    input logic [mbox_pkg::NPROC-1:0][ADDR_W-1:0]  bus_addr,
    input logic [mbox_pkg::NPROC-1:0][DATA_W-1:0]  bus_wdata,
    input logic [mbox_pkg::NPROC-1:0][DATA_W-1:0]  bus_rdata,
    input logic [mbox_pkg::NPROC-1:0]              irq_rx_occ,
    input logic [mbox_pkg::NPROC-1:0]              irq_tx_free,
    input logic [mbox_pkg::NPROC-1:0][NCH-1:0]     flag_q
);
    import mbox_pkg::*;

    logic [NPROC-1:0] wr_cmd, wr_stat, rd_cmd, any_wr;

    for (genvar p = 0; p < int'(NPROC); p++) begin : g_sig
        assign wr_cmd[p]  = bus_valid[p] && bus_write[p] && (bus_addr[p] == ADDR_W'(W_CMD));
        assign wr_stat[p] = bus_valid[p] && bus_write[p] && (bus_addr[p] == ADDR_W'(W_STATUS));
        assign rd_cmd[p]  = bus_valid[p] && !bus_write[p] && (bus_addr[p] == ADDR_W'(W_CMD));
        assign any_wr[p]  = bus_valid[p] && bus_write[p];
    end

    // R1: a reset cycle leaves every interrupt line low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_rx_occ == '0 && irq_tx_free == '0));

    for (genvar p = 0; p < int'(NPROC); p++) begin : g_prop
        localparam int unsigned Q = NPROC - 1 - p;

        // R2: an uncontested set raises the writer's own flags.
        p_set_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_cmd[p] && !wr_cmd[Q]) |=>
            ((flag_q[p] & $past(bus_wdata[p][HI_LSB +: NCH] & ~bus_wdata[p][NCH-1:0]))
              == $past(bus_wdata[p][HI_LSB +: NCH] & ~bus_wdata[p][NCH-1:0])));

        // R3 and R4: clear bits leave the peer's flags at 0 even against a set.
        p_clear_peer_r3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_cmd[p] |=> ((flag_q[Q] & $past(bus_wdata[p][NCH-1:0])) == '0));

        // R5: a rising transmit-free line follows some register write.
        p_tx_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_tx_free[p]) |-> $past(any_wr != '0));

        // R6: a rising receive-occupied line follows some register write.
        p_rx_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_rx_occ[p]) |-> $past(any_wr != '0));

        // R8: the command word reads as 0.
        p_cmd_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rd_cmd[p] |=> (bus_rdata[p] == '0));

        // R8: a status write alone leaves all flags unchanged.
        p_status_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat[p] && !wr_cmd[Q]) |=> $stable(flag_q));
    end
endmodule

bind mbox_flag_ctrl mbox_flag_ctrl_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_rx_occ (irq_rx_occ),
    .irq_tx_free(irq_tx_free),
    .flag_q     (flag_q)
);

// File: tb/mbox_flag_ctrl_test.sv
module mbox_flag_ctrl_test;
    localparam int unsigned NCH    = 6;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned NVEC   = 12;

    typedef struct packed {
        logic        p;
        logic [3:0]  a;
        logic [31:0] d;
        logic [1:0]  rx;
        logic [1:0]  tx;
        logic [5:0]  f0;
        logic [5:0]  f1;
        logic [3:0]  req;
    } vec_t;

    // word 0 ctrl, 1 mask, 2 command, 3 status; rx/tx bits are {proc1, proc0}
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 4'd0, 32'h0000_0003, 2'b00, 2'b00, 6'h00, 6'h00, 4'd7}, // R7 enables on, all masked
        '{1'b0, 4'd1, 32'h003B_003F, 2'b00, 2'b01, 6'h00, 6'h00, 4'd5}, // R5 free ch2 unmasked
        '{1'b0, 4'd2, 32'h0004_0000, 2'b00, 2'b00, 6'h04, 6'h00, 4'd2}, // R2 set ch2
        '{1'b1, 4'd0, 32'h0000_0001, 2'b00, 2'b00, 6'h04, 6'h00, 4'd7}, // R7 p1 rx enable, masked
        '{1'b1, 4'd1, 32'h003F_003B, 2'b10, 2'b00, 6'h04, 6'h00, 4'd6}, // R6 p1 sees ch2
        '{1'b1, 4'd2, 32'h0000_0004, 2'b00, 2'b01, 6'h00, 6'h00, 4'd3}, // R3 p1 clears ch2
        '{1'b1, 4'd2, 32'h0021_0000, 2'b00, 2'b01, 6'h00, 6'h21, 4'd2}, // R2 p1 sets ch5, ch0
        '{1'b0, 4'd2, 32'h0000_0000, 2'b00, 2'b01, 6'h00, 6'h21, 4'd2}, // R2 zeros no effect
        '{1'b0, 4'd2, 32'h0001_0001, 2'b00, 2'b01, 6'h00, 6'h20, 4'd4}, // R4 set+clear ch0
        '{1'b0, 4'd1, 32'h003B_001F, 2'b01, 2'b01, 6'h00, 6'h20, 4'd6}, // R6 p0 sees ch5
        '{1'b0, 4'd0, 32'h0000_0000, 2'b00, 2'b00, 6'h00, 6'h20, 4'd7}, // R7 p0 enables off
        '{1'b0, 4'd3, 32'h0000_003F, 2'b00, 2'b00, 6'h00, 6'h20, 4'd8}  // R8 status write ignored
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]              bus_valid = '0;
    logic [1:0]              bus_write = '0;
    logic [1:0][ADDR_W-1:0]  bus_addr  = '0;
    logic [1:0][DATA_W-1:0]  bus_wdata = '0;
    logic [1:0][DATA_W-1:0]  bus_rdata;
    logic [1:0]              irq_rx_occ;
    logic [1:0]              irq_tx_free;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    mbox_flag_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_rx_occ(irq_rx_occ), .irq_tx_free(irq_tx_free)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int p, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid[p] = 1'b1; bus_write[p] = 1'b1; bus_addr[p] = a; bus_wdata[p] = d;
        @(negedge clk);
        bus_valid[p] = 1'b0; bus_write[p] = 1'b0;
    endtask

    task automatic wr2(input logic [31:0] d0, input logic [31:0] d1);
        @(negedge clk);
        bus_valid = 2'b11; bus_write = 2'b11;
        bus_addr[0] = 4'd2; bus_addr[1] = 4'd2;
        bus_wdata[0] = d0; bus_wdata[1] = d1;
        @(negedge clk);
        bus_valid = 2'b00; bus_write = 2'b00;
    endtask

    task automatic rdw(input int p, input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid[p] = 1'b1; bus_write[p] = 1'b0; bus_addr[p] = a;
        @(negedge clk);
        bus_valid[p] = 1'b0;
        d = bus_rdata[p];
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_rx", {30'd0, irq_rx_occ}, 32'd0);
        check("R1 irq_tx", {30'd0, irq_tx_free}, 32'd0);
        for (int p = 0; p < 2; p++) begin
            rdw(p, 4'd0, rd); check("R1 ctrl", rd, 32'd0);
            rdw(p, 4'd1, rd); check("R1 mask", rd, 32'h003F_003F);
            rdw(p, 4'd3, rd); check("R1 status", rd, 32'd0);
        end

        for (int i = 0; i < int'(NVEC); i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            wr(int'(VEC[i].p), VEC[i].a, VEC[i].d);
            check({tag, " irq_rx"}, {30'd0, irq_rx_occ}, {30'd0, VEC[i].rx});
            check({tag, " irq_tx"}, {30'd0, irq_tx_free}, {30'd0, VEC[i].tx});
            rdw(0, 4'd3, rd); check({tag, " status0"}, rd, {26'd0, VEC[i].f0});
            rdw(1, 4'd3, rd); check({tag, " status1"}, rd, {26'd0, VEC[i].f1});
        end

        // R8 readback and zero reads
        rdw(0, 4'd1, rd); check("R8 mask0 readback", rd, 32'h003B_001F);
        rdw(1, 4'd0, rd); check("R8 ctrl1 readback", rd, 32'h0000_0001);
        rdw(0, 4'd2, rd); check("R8 command reads 0", rd, 32'd0);
        rdw(1, 4'd5, rd); check("R8 unmapped reads 0", rd, 32'd0);

        // R4 cross-processor collision on channel 3: clear wins
        wr2(32'h0008_0000, 32'h0000_0008);
        rdw(0, 4'd3, rd); check("R4 collision status0", rd, 32'd0);

        // R2 simultaneous unrelated sets both land
        wr2(32'h0010_0000, 32'h0002_0000);
        rdw(0, 4'd3, rd); check("R2 dual set status0", rd, 32'h10);
        rdw(1, 4'd3, rd); check("R2 dual set status1", rd, 32'h22);

        // R5 tx line with enable back on: ch2 of p0 is free and unmasked
        wr(0, 4'd0, 32'h0000_0002);
        check("R5 tx0 re-enabled", {30'd0, irq_tx_free}, 32'h1);
        // R3 p0 clears p1 ch5, ch1
        wr(0, 4'd2, 32'h0000_0022);
        rdw(1, 4'd3, rd); check("R3 clear peer status1", rd, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule